// File: doc/BRIEF.md
# SATA Port Error and Queued-Slot Register Block

This block holds two software-visible registers for a single SATA host port. The first is an error register. Hardware event pulses set its bits, and software clears them by writing ones. Four of its bits mark fatal conditions. While any fatal bit is set, the block drives a stop request that ends the transfer in flight. The second register is a native-command-queuing active-slot register with one bit per command slot. Software sets its bits by writing ones. The bits are retired only when a Set Device Bits completion arrives carrying a mask of finished slots.

Both registers sit on a minimal word-addressed bus. A cycle with `bus_sel` and `bus_we` high is a write. Read data is a combinational function of `bus_addr`. The error register is at word 0 and the active-slot register is at word 1. Software is expected to mark a queued slot active before it issues that slot to the command engine. The command-issue register itself lives outside this block.

Top module: `sata_perr_slot_regs`

## Requirements
- R1: After reset, reads of word 0 (error) and word 1 (active slots) return 0, and `stop_xfer` is 0.
- R2: A one-cycle event pulse sets its error bit, and the bit is readable from the following cycle. The bit positions are: internal memory-access failure at bit 11, protocol violation at bit 10, persistent communication/integrity error at bit 9, transient unrecovered data error at bit 8, recovered communication loss at bit 1, and retry-recovered data error at bit 0.
- R3: A write to word 0 clears each error bit whose write-data bit is 1 and leaves the other bits unchanged. A bus write never sets an error bit.
- R4: Error bits 31:12 and 7:2 always read 0, including after writes of all ones and with every event asserted.
- R5: When an event and a write-one-to-clear hit the same error bit in one cycle, the bit ends set.
- R6: `stop_xfer` is 1 exactly while any of error bits 11:8 is set. It is not raised by bits 1:0. It stays 1 during the clearing write and is 0 in the cycle after the last fatal bit is cleared.
- R7: A write to word 1 sets each active-slot bit whose write-data bit is 1. Write-data zeros have no effect.
- R8: A completion (`sdb_valid` high) clears the active-slot bits set in `sdb_done_mask` and no others. No bus write can clear an active-slot bit.
- R9: When a software set and a completion clear hit the same active-slot bit in one cycle, the bit ends set.
- R10: Words other than 0 and 1 read as 0, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus cycle select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_internal_fail | input | 1 | Memory-access abort event (bit 11) |
| evt_protocol | input | 1 | Protocol violation event (bit 10) |
| evt_persist_comm | input | 1 | Persistent comm/integrity event (bit 9) |
| evt_transient_data | input | 1 | Transient data integrity event (bit 8) |
| evt_comm_recovered | input | 1 | Recovered comm loss event (bit 1) |
| evt_data_recovered | input | 1 | Retry-recovered data event (bit 0) |
| sdb_valid | input | 1 | Set Device Bits completion strobe |
| sdb_done_mask | input | SLOTS | Slots finished by the completion |
| stop_xfer | output | 1 | Stop current transfer request |

## Verification
The directed tests aim at the same-cycle collisions. A design with the wrong priority would lose an error event under a concurrent clear, or drop a freshly queued slot under a concurrent completion. The tests also try to set error bits or clear slot bits through the bus. A register with the wrong write semantics would then show phantom errors or lose slots. The stop output is sampled during the clearing write and again one cycle later, which catches a registered or early-dropping stop. Writes of all ones to the error register and to unmapped words expose reserved bits that were stored or an address decode that aliases.

// File: rtl/sata_perr_pkg.sv
// Package: shared constants and types for the port error / active-slot block.
// Assumes a 32-bit register bus and word addressing.
package sata_perr_pkg;
    localparam int REG_W = 32;
    localparam int ERR_WORD = 0;
    localparam int ACT_WORD = 1;

    localparam int BIT_INTERNAL  = 11;
    localparam int BIT_PROTOCOL  = 10;
    localparam int BIT_PERSIST   = 9;
    localparam int BIT_TRANSIENT = 8;
    localparam int BIT_COMM_REC  = 1;
    localparam int BIT_DATA_REC  = 0;

    localparam logic [REG_W-1:0] ERR_IMPL_MASK  = 32'h0000_0F03;
    localparam logic [REG_W-1:0] ERR_FATAL_MASK = 32'h0000_0F00;

    typedef struct packed {
        logic internal_fail;
        logic protocol;
        logic persist_comm;
        logic transient_data;
        logic comm_recovered;
        logic data_recovered;
    } err_evt_t;

    // Places each event on its register bit position.
    function automatic logic [REG_W-1:0] evt_to_vec(input err_evt_t e);
        logic [REG_W-1:0] v;
        v = '0;
        v[BIT_INTERNAL]  = e.internal_fail;
        v[BIT_PROTOCOL]  = e.protocol;
        v[BIT_PERSIST]   = e.persist_comm;
        v[BIT_TRANSIENT] = e.transient_data;
        v[BIT_COMM_REC]  = e.comm_recovered;
        v[BIT_DATA_REC]  = e.data_recovered;
        return v;
    endfunction
endpackage

// File: rtl/sata_perr_err_reg.sv
// Error register: event-set, write-one-to-clear bits at the implemented
// positions only; reserved positions are constant zero. Set beats clear.
// Raises stop_xfer combinationally from the fatal group.
// Assumes clr_en is a single-cycle qualified bus write to the error word.
module sata_perr_err_reg
    import sata_perr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  err_evt_t         evt,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_mask,
    output logic [REG_W-1:0] err_q,
    output logic             stop_xfer
);
    logic [REG_W-1:0] set_vec;

    // Event pulses mapped onto register positions.
    assign set_vec = evt_to_vec(evt);

    for (genvar g = 0; g < REG_W; g++) begin : g_bit
        if (ERR_IMPL_MASK[g]) begin : g_impl
            // One stored error bit: reset, then set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    err_q[g] <= 1'b0;
                else if (set_vec[g])
                    err_q[g] <= 1'b1;
                else if (clr_en && clr_mask[g])
                    err_q[g] <= 1'b0;
            end
        end else begin : g_rsvd
            assign err_q[g] = 1'b0;
        end
    end

    // Fatal group drives the stop request.
    assign stop_xfer = |(err_q & ERR_FATAL_MASK);

    // R2: every pulsed event is visible in the register on the next cycle.
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((err_q & $past(set_vec)) == $past(set_vec)));

    // R3: a bit can only rise because of an event, never from the bus.
    a_r3_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_q & ~$past(err_q) & ~$past(set_vec)) == '0));

    // R3: a bit can only fall where a clearing write carried a one.
    a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(err_q) & ~err_q & ~($past(clr_en) ? $past(clr_mask) : '0)) == '0));

    // R6: stop only drops after a clearing write.
    a_r6_stop_drop_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_xfer) |-> $past(clr_en));
endmodule

// File: rtl/sata_perr_slot_reg.sv
// Active-slot register: software write-one-to-set, completion-mask clear,
// set beats clear in the same cycle.
// Assumes SLOTS between 1 and 32 and single-cycle set/done strobes.
module sata_perr_slot_reg #(
    parameter int SLOTS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [SLOTS-1:0] set_mask,
    input  logic             done_en,
    input  logic [SLOTS-1:0] done_mask,
    output logic [SLOTS-1:0] act_q
);
    logic [SLOTS-1:0] set_eff;
    logic [SLOTS-1:0] clr_eff;

    // Qualify the set and clear masks by their strobes.
    always_comb begin
        set_eff = set_en  ? set_mask  : '0;
        clr_eff = done_en ? done_mask : '0;
    end

    // Slot state update: retire completed slots, then apply software sets.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else
            act_q <= (act_q & ~clr_eff) | set_eff;
    end

    // R7: bits rise only where software wrote a one.
    a_r7_rise_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((act_q & ~$past(act_q) & ~($past(set_en) ? $past(set_mask) : '0)) == '0));

    // R8: bits fall only where a completion named them.
    a_r8_fall_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(act_q) & ~act_q & ~($past(done_en) ? $past(done_mask) : '0)) == '0));

    // R9: a concurrent set survives the completion.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && set_mask != '0) |=> ((act_q & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/sata_perr_slot_regs.sv
// Top: word-addressed bus decode and read mux over the error register and
// active-slot register of one SATA port.
// Assumes SLOTS <= 32; reads are combinational on bus_addr.
module sata_perr_slot_regs
    import sata_perr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SLOTS  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              evt_internal_fail,
    input  logic              evt_protocol,
    input  logic              evt_persist_comm,
    input  logic              evt_transient_data,
    input  logic              evt_comm_recovered,
    input  logic              evt_data_recovered,
    input  logic              sdb_valid,
    input  logic [SLOTS-1:0]  sdb_done_mask,
    output logic              stop_xfer
);
    localparam logic [ADDR_W-1:0] A_ERR = ADDR_W'(ERR_WORD);
    localparam logic [ADDR_W-1:0] A_ACT = ADDR_W'(ACT_WORD);

    logic             wr_err;
    logic             wr_act;
    err_evt_t         evt;
    logic [REG_W-1:0] err_q;
    logic [SLOTS-1:0] act_q;
    logic [REG_W-1:0] act_rd;

    // Write decode per register word.
    assign wr_err = bus_sel && bus_we && (bus_addr == A_ERR);
    assign wr_act = bus_sel && bus_we && (bus_addr == A_ACT);

    // Gather event pins into the shared struct.
    assign evt = '{internal_fail:  evt_internal_fail,
                   protocol:       evt_protocol,
                   persist_comm:   evt_persist_comm,
                   transient_data: evt_transient_data,
                   comm_recovered: evt_comm_recovered,
                   data_recovered: evt_data_recovered};

    sata_perr_err_reg u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .clr_en   (wr_err),
        .clr_mask (bus_wdata),
        .err_q    (err_q),
        .stop_xfer(stop_xfer)
    );

    sata_perr_slot_reg #(.SLOTS(SLOTS)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (wr_act),
        .set_mask (bus_wdata[SLOTS-1:0]),
        .done_en  (sdb_valid),
        .done_mask(sdb_done_mask),
        .act_q    (act_q)
    );

    // Zero-extend the slot vector to the bus width.
    assign act_rd = REG_W'(act_q);

    // Read mux; unmapped words return zero.
    always_comb begin
        case (bus_addr)
            A_ERR:   bus_rdata = err_q;
            A_ACT:   bus_rdata = act_rd;
            default: bus_rdata = '0;
        endcase
    end

    // R4: reserved error positions never read back as one.
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_ERR) |-> ((bus_rdata & ~ERR_IMPL_MASK) == '0));

    // R6: a fatal event raises stop on the next cycle.
    a_r6_fatal_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_internal_fail || evt_protocol || evt_persist_comm || evt_transient_data) |=> stop_xfer);

    // R10: a write to an unmapped word leaves the error register as it was unless events fire.
    a_r10_unmapped_no_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr != A_ERR) |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: tb/tb_sata_perr_slot_regs.sv
`timescale 1ns/100ps
module tb_sata_perr_slot_regs;
    localparam int ADDR_W = 4;
    localparam int SLOTS  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [5:0]        evt = '0;   // {int, proto, persist, transient, commrec, datarec}
    logic              sdb_valid = 1'b0;
    logic [SLOTS-1:0]  sdb_done_mask = '0;
    logic              stop_xfer;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sata_perr_slot_regs #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_internal_fail(evt[5]), .evt_protocol(evt[4]),
        .evt_persist_comm(evt[3]), .evt_transient_data(evt[2]),
        .evt_comm_recovered(evt[1]), .evt_data_recovered(evt[0]),
        .sdb_valid(sdb_valid), .sdb_done_mask(sdb_done_mask),
        .stop_xfer(stop_xfer)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock cycle of stimulus, driven at a negedge and removed at the next.
    task automatic cyc(input logic we, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       input logic [5:0] e, input logic sv, input logic [31:0] sm);
        @(negedge clk);
        bus_sel = we; bus_we = we; bus_addr = a; bus_wdata = d;
        evt = e; sdb_valid = sv; sdb_done_mask = sm;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; evt = '0; sdb_valid = 1'b0; sdb_done_mask = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(0, d); chk("R1 err reset", d, 0);
        rd(1, d); chk("R1 act reset", d, 0);
        chk("R1 stop reset", {31'b0, stop_xfer}, 0);
    endtask

    task automatic t_events;
        logic [31:0] d;
        int pos[6] = '{0, 1, 8, 9, 10, 11};
        for (int i = 0; i < 6; i++) begin
            cyc(0, 0, 0, 6'(1) << i, 0, 0);
            rd(0, d); chk("R2 event bit position", d, 32'(1) << pos[i]);
            cyc(1, 0, 32'hFFFF_FFFF, 0, 0, 0);
        end
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        cyc(0, 0, 0, 6'b100011, 0, 0);
        cyc(1, 0, 32'h0, 0, 0, 0);
        rd(0, d); chk("R3 write zero keeps", d, 32'h0803);
        cyc(1, 0, 32'h2, 0, 0, 0);
        rd(0, d); chk("R3 clear one bit", d, 32'h0801);
        cyc(1, 0, 32'h0801, 0, 0, 0);
        cyc(1, 0, 32'hFFFF_FFFF, 0, 0, 0);
        rd(0, d); chk("R3 no software set", d, 0);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        cyc(0, 0, 0, 6'b111111, 0, 0);
        rd(0, d); chk("R4 reserved read zero", d, 32'h0F03);
        cyc(1, 0, 32'hFFFF_FFFF, 0, 0, 0);
        rd(0, d); chk("R4 cleared all", d, 0);
    endtask

    task automatic t_err_collision;
        logic [31:0] d;
        cyc(0, 0, 0, 6'b010000, 0, 0);
        cyc(1, 0, 32'h0000_0401, 6'b010001, 0, 0);
        rd(0, d); chk("R5 set beats clear", d, 32'h0401);
        cyc(1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    endtask

    task automatic t_stop;
        cyc(0, 0, 0, 6'b000011, 0, 0);
        #1 chk("R6 recovered bits no stop", {31'b0, stop_xfer}, 0);
        cyc(0, 0, 0, 6'b001000, 0, 0);
        #1 chk("R6 stop on bit 9", {31'b0, stop_xfer}, 1);
        cyc(0, 0, 0, 6'b100000, 0, 0);
        cyc(1, 0, 32'h0200, 0, 0, 0);
        #1 chk("R6 stop held by bit 11", {31'b0, stop_xfer}, 1);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 0; bus_wdata = 32'h0800;
        #1 chk("R6 stop during clear cycle", {31'b0, stop_xfer}, 1);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        #1 chk("R6 stop low after last clear", {31'b0, stop_xfer}, 0);
        cyc(1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    endtask

    task automatic t_slot_set;
        logic [31:0] d;
        cyc(1, 1, 32'h5, 0, 0, 0);
        rd(1, d); chk("R7 set slots", d, 32'h5);
        cyc(1, 1, 32'h0, 0, 0, 0);
        rd(1, d); chk("R7 zero write no effect", d, 32'h5);
        cyc(1, 1, 32'h8000_00A0, 0, 0, 0);
        rd(1, d); chk("R7 accumulate", d, 32'h8000_00A5);
    endtask

    task automatic t_sdb;
        logic [31:0] d;
        cyc(0, 1, 0, 0, 1, 32'h0000_0105);
        rd(1, d); chk("R8 completion clears mask", d, 32'h8000_00A0);
        cyc(1, 1, 32'h0, 0, 0, 0);
        rd(1, d); chk("R8 bus cannot clear", d, 32'h8000_00A0);
    endtask

    task automatic t_slot_collision;
        logic [31:0] d;
        cyc(1, 1, 32'h10, 0, 1, 32'h90);
        rd(1, d); chk("R9 set beats completion", d, 32'h8000_0030);
    endtask

    task automatic t_addr;
        logic [31:0] d;
        cyc(0, 0, 0, 6'b000001, 0, 0);
        cyc(1, 5, 32'hFFFF_FFFF, 0, 0, 0);
        rd(5, d); chk("R10 unmapped reads zero", d, 0);
        rd(0, d); chk("R10 err untouched", d, 32'h1);
        rd(1, d); chk("R10 act untouched", d, 32'h8000_0030);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_events();
        t_w1c();
        t_reserved();
        t_err_collision();
        t_stop();
        t_slot_set();
        t_sdb();
        t_slot_collision();
        t_addr();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule